// File: doc/BRIEF.md
# Masked-Write General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port that software controls through a 32-bit register bus. Pin direction changes through two write-only command registers. One turns the marked pins into outputs and the other turns the marked pins back into inputs. A zero bit in either register leaves its pin as it was, so software can change one pin without first reading the register.

Output levels are written through two registers, one for each half-word of pins. Each write carries a per-pin enable mask and the new levels. Only the enabled pins take the new level, which removes the read-modify-write sequence from software. A level may be written while the pin is still an input. The port keeps it and drives it as soon as the pin becomes an output. The pad levels pass through a synchronizer and can be read back from an input register.

The bus is a single-cycle write strobe with a combinational read data path. The pad side has an output vector, an output-enable vector and an input vector.

Top module: `gpio_port`

## Requirements
- R1: After reset all pins are inputs (padOe all zero) and all stored output levels (padOut) are zero.
- R2: A write to offset 0x00 makes each pin whose data bit is 1 an output from the next cycle. Pins whose data bit is 0 keep their direction.
- R3: A write to offset 0x04 makes each pin whose data bit is 1 an input from the next cycle. Pins whose data bit is 0 keep their direction.
- R4: A write to offset 0x08 updates pins 0 to 15. Data bit 16+k is the enable for pin k and data bit k is its new level. Pins without enable keep their level.
- R5: A write to offset 0x0C updates pins 16 to 31. Data bit 16+k is the enable for pin 16+k and data bit k is its new level. Pins without enable keep their level.
- R6: The stored output level of a pin is kept while the pin is an input. It appears on padOut at all times and is driven as soon as padOe turns on, with no rewrite needed.
- R7: Reading offset 0x10 returns the pad input levels, one bit per pin. A change on padIn becomes visible after exactly two rising clock edges.
- R8: Reading offset 0x00 or 0x04 returns the output-enable vector. Reading 0x08 or 0x0C returns the stored levels of that half in bits 15:0, with bits 31:16 read as zero.
- R9: Writes to any other offset change no direction or level, and reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the current bus cycle |
| addr | input | 8 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| padIn | input | 32 | Pad input levels, asynchronous |
| padOut | output | 32 | Stored output levels |
| padOe | output | 32 | Output enables, 1 = pin drives |

## Verification
The bench builds the block with its defaults: two 16-pin halves, a two-stage synchronizer and an 8-bit offset. With these values every pin of both output registers and every bit of the direction vector can be reached by random masks. The bench also drives writes to unmapped offsets. Directed cases cover a level written while the pin is an input and then enabled, all-ones and all-zero masks, and the exact two-edge input latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam logic [7:0] OFS_DIR_OUT = 8'h00;
  localparam logic [7:0] OFS_DIR_IN  = 8'h04;
  localparam logic [7:0] OFS_LVL_LO  = 8'h08;
  localparam logic [7:0] OFS_LVL_HI  = 8'h0C;
  localparam logic [7:0] OFS_PINS    = 8'h10;

  typedef struct packed {
    logic setDir;
    logic clrDir;
    logic wrLow;
    logic wrHigh;
  } strobe_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_DIR, RD_LVL_LO, RD_LVL_HI, RD_PINS
  } rdsel_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb,
  output rdsel_t            rdSel
);
  logic hitSet, hitClr, hitLo, hitHi, hitPins;

  always_comb begin
    hitSet  = (addr == ADDR_W'(OFS_DIR_OUT));
    hitClr  = (addr == ADDR_W'(OFS_DIR_IN));
    hitLo   = (addr == ADDR_W'(OFS_LVL_LO));
    hitHi   = (addr == ADDR_W'(OFS_LVL_HI));
    hitPins = (addr == ADDR_W'(OFS_PINS));

    strb.setDir = rstN && wrEn && hitSet;
    strb.clrDir = rstN && wrEn && hitClr;
    strb.wrLow  = rstN && wrEn && hitLo;
    strb.wrHigh = rstN && wrEn && hitHi;

    if (hitSet || hitClr) rdSel = RD_DIR;
    else if (hitLo)       rdSel = RD_LVL_LO;
    else if (hitHi)       rdSel = RD_LVL_HI;
    else if (hitPins)     rdSel = RD_PINS;
    else                  rdSel = RD_NONE;
  end
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  rdsel_t              rdSel,
  input  logic [2*HALF_W-1:0] wrData,
  output logic [2*HALF_W-1:0] rdData,
  input  logic [2*HALF_W-1:0] padIn,
  output logic [2*HALF_W-1:0] padOut,
  output logic [2*HALF_W-1:0] padOe
);
  localparam int PIN_W = 2 * HALF_W;

  logic [PIN_W-1:0]  oeQ;
  logic [PIN_W-1:0]  lvlQ;
  logic [HALF_W-1:0] wrMask, wrVal;
  logic [PIN_W-1:0]  syncQ [SYNC_STAGES];

  assign wrMask = wrData[PIN_W-1:HALF_W];
  assign wrVal  = wrData[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeQ <= '0;
    end else if (strb.setDir) begin
      oeQ <= oeQ | wrData;
    end else if (strb.clrDir) begin
      oeQ <= oeQ & ~wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlQ <= '0;
    end else begin
      if (strb.wrLow)
        lvlQ[HALF_W-1:0] <= (lvlQ[HALF_W-1:0] & ~wrMask) | (wrVal & wrMask);
      if (strb.wrHigh)
        lvlQ[PIN_W-1:HALF_W] <= (lvlQ[PIN_W-1:HALF_W] & ~wrMask) | (wrVal & wrMask);
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[0] <= '0;
        else       syncQ[0] <= padIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_DIR:    rdData = oeQ;
      RD_LVL_LO: rdData = {{HALF_W{1'b0}}, lvlQ[HALF_W-1:0]};
      RD_LVL_HI: rdData = {{HALF_W{1'b0}}, lvlQ[PIN_W-1:HALF_W]};
      RD_PINS:   rdData = syncQ[SYNC_STAGES-1];
      default:   rdData = '0;
    endcase
  end

  assign padOut = lvlQ;
  assign padOe  = oeQ;

  assert_dir_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDir |=> ((oeQ & $past(wrData)) == $past(wrData)));

  assert_dir_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrDir |=> ((oeQ & $past(wrData)) == '0));

  assert_lo_unmasked_keep_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLow |=> (((lvlQ[HALF_W-1:0] ^ $past(lvlQ[HALF_W-1:0]))
                     & ~$past(wrMask)) == '0));

  assert_hi_unmasked_keep_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrHigh |=> (((lvlQ[PIN_W-1:HALF_W] ^ $past(lvlQ[PIN_W-1:HALF_W]))
                      & ~$past(wrMask)) == '0));

  assert_lvl_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrLow || strb.wrHigh) |=> $stable(lvlQ));

  assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setDir || strb.clrDir) |=> $stable(oeQ));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*HALF_W-1:0] wrData,
  output logic [2*HALF_W-1:0] rdData,
  input  logic [2*HALF_W-1:0] padIn,
  output logic [2*HALF_W-1:0] padOut,
  output logic [2*HALF_W-1:0] padOe
);
  strobe_t strb;
  rdsel_t  rdSel;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .rstN  (rstN),
    .wrEn  (wrEn),
    .addr  (addr),
    .strb  (strb),
    .rdSel (rdSel)
  );

  gpio_port_dp #(.HALF_W(HALF_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdSel  (rdSel),
    .wrData (wrData),
    .rdData (rdData),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe)
  );
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe;

  logic [31:0] oeM = '0;
  logic [31:0] lvlM = '0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  function automatic logic [15:0] mergeHalf(logic [15:0] old, logic [31:0] d);
    return (old & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h00, 8'h04: return oeM;
      8'h08: return {16'h0, lvlM[15:0]};
      8'h0C: return {16'h0, lvlM[31:16]};
      8'h10: return padIn;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      8'h00: oeM = oeM | d;
      8'h04: oeM = oeM & ~d;
      8'h08: lvlM[15:0] = mergeHalf(lvlM[15:0], d);
      8'h0C: lvlM[31:16] = mergeHalf(lvlM[31:16], d);
      default: ;
    endcase
  endtask

  task automatic checkPads(string tag);
    check({tag, " padOe"}, padOe, oeM);
    check({tag, " padOut"}, padOut, lvlM);
  endtask

  task automatic busRead(string tag, logic [7:0] a);
    wrEn = 1'b0; addr = a;
    #1;
    check(tag, rdData, expRead(a));
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [6];
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h14, 8'h40};
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkPads("R1 reset");

    // R6: level written while input is held, driven once enabled
    busWrite(8'h08, 32'h0001_0001);
    checkPads("R6 level while input");
    busWrite(8'h00, 32'h0000_0001);
    checkPads("R6 enable after level");
    check("R6 pin0 drives", padOut[0] & padOe[0], 1'b1);

    // R4/R5 all-ones and all-zero masks
    busWrite(8'h0C, 32'hFFFF_A5A5);
    checkPads("R5 full mask high");
    busWrite(8'h0C, 32'h0000_0000);
    checkPads("R5 empty mask high");
    busWrite(8'h08, 32'hFFFF_3C3C);
    checkPads("R4 full mask low");
    busWrite(8'h08, 32'h00F0_FFFF);
    checkPads("R4 partial mask low");

    // R2/R3 directed
    busWrite(8'h00, 32'hFFFF_FFFF);
    checkPads("R2 all outputs");
    busWrite(8'h04, 32'h0F0F_0000);
    checkPads("R3 partial to inputs");
    busRead("R8 dir read via 0x04", 8'h04);
    busRead("R8 dir read via 0x00", 8'h00);
    busRead("R8 low level read", 8'h08);
    busRead("R8 high level read", 8'h0C);

    // R9 unmapped
    busWrite(8'h14, 32'hFFFF_FFFF);
    checkPads("R9 unmapped write 0x14");
    busWrite(8'h10, 32'hFFFF_0000);
    checkPads("R9 write to input reg");
    busRead("R9 unmapped read", 8'h20);

    // R7 synchronizer latency
    @(negedge clk);
    padIn = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    addr = 8'h10; #1;
    check("R7 not yet after one edge", rdData, 32'h0);
    @(posedge clk); #1;
    check("R7 visible after two edges", rdData, 32'hDEAD_BEEF);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = addrs[$urandom_range(5)];
      busWrite(a, $urandom);
      checkPads("R2 R3 R4 R5 R9 random");
      if ((i % 8) == 0) begin
        padIn = $urandom;
        repeat (2) @(negedge clk);
        busRead("R7 random input read", 8'h10);
      end
      busRead("R8 random read", addrs[$urandom_range(5)]);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule